// File: doc/BRIEF.md
# Dual-Channel Reload Down-Counter Timer

This block is a register-mapped timer with two identical 32-bit channels. Each channel counts down on a prescaled copy of the system clock and raises an underflow flag when a decrement is due while the count is zero. It can either stop after that event (one-shot) or reload and keep running (periodic). Each channel drives its own level interrupt, which is high while both the underflow flag and the channel's interrupt enable are set. A free-running time base is made by loading all-ones, running periodically, and inverting the count on read.

Software reaches each channel through a 16-byte window on a single-cycle register bus. Writes are captured on the clock edge while select and write are high. Read data is combinational from the address. A start command copies reload value 1 into the counter. Reload value 2 is plain storage.

Top module: `duo_reload_timer`

## Requirements
- R1: Channel c occupies byte addresses 0x10*c to 0x10*c+0xF. Within a window, control is at +0x0, the counter at +0x4, reload value 1 at +0x8 and reload value 2 at +0xC. All four read back what was written, apart from the control behaviour given below. An address with a nonzero low two bits is ignored on write and reads as zero.
- R2: Control fields are: bits 12:10 clock select, bit 5 output level, bit 4 periodic enable, bit 3 interrupt enable, bit 2 underflow flag, bit 1 run enable and bit 0 start. The start bit always reads 0. Every register resets to zero.
- R3: A control write with start and run enable both 1 loads the counter from reload value 1 and restarts the prescaler. Start with run enable 0 leaves the counter unchanged.
- R4: While running, the counter decreases by one every D clock cycles, with D = 2, 8, 32 or 64 for clock select 0, 1, 2 or 3 and D = 2 for select 4 to 7. The first decrement falls on the D-th edge after the starting write.
- R5: A decrement that falls due while the count is zero is an underflow. It sets the flag and toggles the output level, so a start from value N underflows on edge (N+1)*D after the start.
- R6: With periodic enable 1, an underflow reloads the counter from reload value 1 and counting continues.
- R7: With periodic enable 0, an underflow clears run enable and the count stays at zero.
- R8: Interrupt output c is 1 exactly while channel c's flag and interrupt enable are both 1.
- R9: Writing 0 to the flag clears it. Writing 1 leaves it unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R10: Writing all zeros to control stops the counter and drops the interrupt.
- R11: A counter write loads that value directly. Setting run enable without start counts down from the present value. Activity on one channel never changes the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from busAddr |
| irq | output | NUM_CH | Per-channel interrupt level |

## Verification
The hardest case to reach is a clearing write to the flag that lands on the same edge as a periodic underflow, since the two sources then contend for one bit. The bench counts edges from the starting write and issues the write so that it is captured exactly on the computed underflow edge. It then reads back the flag and the output level. The one-shot timing is swept over every divide setting, and over start values of zero and above, with each edge position derived from (N+1)*D.

// File: rtl/rtmr_pkg.sv
`timescale 1ns/1ps
package rtmr_pkg;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_REL1  = 2'd2,
    REG_REL2  = 2'd3
  } regSel_e;

  localparam int B_START  = 0;
  localparam int B_RUN    = 1;
  localparam int B_UF     = 2;
  localparam int B_IRQEN  = 3;
  localparam int B_PERIOD = 4;
  localparam int B_OUTLV  = 5;
  localparam int SEL_LO   = 10;
  localparam int SEL_HI   = 12;

  // strobes from a channel's control to its datapath
  typedef struct packed {
    logic wrCount;
    logic wrRel1;
    logic wrRel2;
    logic loadRel1;
    logic dec;
  } rtmrStrobe_t;

endpackage

// File: rtl/rtmr_datapath.sv
`timescale 1ns/1ps
module rtmr_datapath
  import rtmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  rtmrStrobe_t      strobe,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] rel1,
  output logic [CNT_W-1:0] rel2,
  output logic             countZero
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      rel1  <= '0;
      rel2  <= '0;
    end else begin
      if (strobe.wrRel1) rel1 <= wdata;
      if (strobe.wrRel2) rel2 <= wdata;
      if (strobe.wrCount)       count <= wdata;
      else if (strobe.loadRel1) count <= rel1;
      else if (strobe.dec)      count <= count - CNT_W'(1);
    end
  end

  assign countZero = (count == '0);

  AST_LOAD_REL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadRel1 && !strobe.wrCount) |=> (count == $past(rel1))); // R3

  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !strobe.loadRel1 && !strobe.wrCount) |=>
      (count == $past(count) - CNT_W'(1))); // R4

  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (countZero && !strobe.loadRel1 && !strobe.wrCount) |=> countZero); // R7

endmodule

// File: rtl/rtmr_ctrl.sv
`timescale 1ns/1ps
module rtmr_ctrl
  import rtmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_A  = 2,
  parameter int DIV_B  = 8,
  parameter int DIV_C  = 32,
  parameter int DIV_D  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chWr,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              countZero,
  output rtmrStrobe_t       strobe,
  output logic [DATA_W-1:0] ctrlRead,
  output logic              irq
);

  localparam int DIV_AB  = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int DIV_CD  = (DIV_C > DIV_D) ? DIV_C : DIV_D;
  localparam int DIV_MAX = (DIV_AB > DIV_CD) ? DIV_AB : DIV_CD;
  localparam int PRE_W   = $clog2(DIV_MAX);

  logic [2:0]       clkSel, clkSelN;
  logic             outLvl, outLvlN;
  logic             perEn, perEnN;
  logic             irqEn, irqEnN;
  logic             ufFlag, ufFlagN;
  logic             runEn, runEnN;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divLimit;
  logic             ctrlWrite, start, tick, underflow;

  logic unusedWdata;
  assign unusedWdata = ^{wdata[DATA_W-1:SEL_HI+1], wdata[SEL_LO-1:B_OUTLV+1]};

  assign ctrlWrite = chWr && (regSel == REG_CTRL);
  assign start     = ctrlWrite && wdata[B_START] && wdata[B_RUN];

  always_comb begin
    case (clkSel)
      3'd1:    divLimit = PRE_W'(DIV_B - 1);
      3'd2:    divLimit = PRE_W'(DIV_C - 1);
      3'd3:    divLimit = PRE_W'(DIV_D - 1);
      default: divLimit = PRE_W'(DIV_A - 1);
    endcase
  end

  assign tick      = runEn && (preCnt == divLimit);
  assign underflow = tick && countZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       preCnt <= '0;
    else if (!runEn || start || tick) preCnt <= '0;
    else                             preCnt <= preCnt + PRE_W'(1);
  end

  // control field next state: bus write wins, except the flag, where a set wins
  always_comb begin
    clkSelN = clkSel;
    outLvlN = outLvl;
    perEnN  = perEn;
    irqEnN  = irqEn;
    ufFlagN = ufFlag;
    runEnN  = runEn;
    if (underflow) begin
      ufFlagN = 1'b1;
      outLvlN = ~outLvl;
      if (!perEn) runEnN = 1'b0;
    end
    if (ctrlWrite) begin
      clkSelN = wdata[SEL_HI:SEL_LO];
      outLvlN = wdata[B_OUTLV];
      perEnN  = wdata[B_PERIOD];
      irqEnN  = wdata[B_IRQEN];
      runEnN  = wdata[B_RUN];
      ufFlagN = (ufFlag && wdata[B_UF]) || underflow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel <= '0;
      outLvl <= 1'b0;
      perEn  <= 1'b0;
      irqEn  <= 1'b0;
      ufFlag <= 1'b0;
      runEn  <= 1'b0;
    end else begin
      clkSel <= clkSelN;
      outLvl <= outLvlN;
      perEn  <= perEnN;
      irqEn  <= irqEnN;
      ufFlag <= ufFlagN;
      runEn  <= runEnN;
    end
  end

  always_comb begin
    strobe.wrCount  = chWr && (regSel == REG_COUNT);
    strobe.wrRel1   = chWr && (regSel == REG_REL1);
    strobe.wrRel2   = chWr && (regSel == REG_REL2);
    strobe.loadRel1 = start || (underflow && perEn);
    strobe.dec      = tick && !countZero;
  end

  always_comb begin
    ctrlRead                = '0;
    ctrlRead[SEL_HI:SEL_LO] = clkSel;
    ctrlRead[B_OUTLV]       = outLvl;
    ctrlRead[B_PERIOD]      = perEn;
    ctrlRead[B_IRQEN]       = irqEn;
    ctrlRead[B_UF]          = ufFlag;
    ctrlRead[B_RUN]         = runEn;
  end

  assign irq = ufFlag && irqEn;

  AST_UF_SET: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> ufFlag); // R5

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !perEn && !ctrlWrite) |=> !runEn); // R7

  AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick); // R4

  AST_UF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && !wdata[B_UF] && !underflow) |=> !ufFlag); // R9

  AST_STOP_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && (wdata == '0)) |=> (!irq && !runEn)); // R10

endmodule

// File: rtl/duo_reload_timer.sv
`timescale 1ns/1ps
module duo_reload_timer
  import rtmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int DIV_A  = 2,
  parameter int DIV_B  = 8,
  parameter int DIV_C  = 32,
  parameter int DIV_D  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] irq
);

  localparam int CH_W = ADDR_W - 4;

  logic [CH_W-1:0]   chIdx;
  logic [1:0]        regSel;
  logic              addrOk;
  logic [DATA_W-1:0] chRead [NUM_CH];

  assign chIdx  = busAddr[ADDR_W-1:4];
  assign regSel = busAddr[3:2];
  assign addrOk = (busAddr[1:0] == 2'b00);

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    rtmrStrobe_t       strobe;
    logic              chWr, countZero;
    logic [DATA_W-1:0] ctrlRd, count, rel1, rel2;

    assign chWr = busSel && busWrite && addrOk && (chIdx == CH_W'(g));

    rtmr_ctrl #(
      .DATA_W(DATA_W), .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .DIV_D(DIV_D)
    ) uCtrl (
      .clk(clk), .rstN(rstN), .chWr(chWr), .regSel(regSel), .wdata(busWdata),
      .countZero(countZero), .strobe(strobe), .ctrlRead(ctrlRd), .irq(irq[g])
    );

    rtmr_datapath #(.CNT_W(DATA_W)) uDp (
      .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata),
      .count(count), .rel1(rel1), .rel2(rel2), .countZero(countZero)
    );

    always_comb begin
      case (regSel)
        REG_CTRL:  chRead[g] = ctrlRd;
        REG_COUNT: chRead[g] = count;
        REG_REL1:  chRead[g] = rel1;
        default:   chRead[g] = rel2;
      endcase
    end
  end

  always_comb begin
    busRdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addrOk && (chIdx == CH_W'(c))) busRdata = chRead[c];
    end
  end

endmodule

// File: tb/sim_duo_reload_timer.sv
`timescale 1ns/1ps
module sim_duo_reload_timer;

  localparam int ADDR_W = 5;
  localparam logic [31:0] TRIG = 32'h1, RUN = 32'h2, UF = 32'h4,
                          IRQEN = 32'h8, PER = 32'h10, OUTLV = 32'h20;

  logic              clk = 1'b0;
  logic              rstN;
  logic              busSel, busWrite;
  logic [ADDR_W-1:0] busAddr;
  logic [31:0]       busWdata, busRdata;
  logic [1:0]        irq;

  int cyc = 0;
  int nChk = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  duo_reload_timer u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    busAddr = a;
    #0.1;
    d = busRdata;
  endtask

  task automatic rdChk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic waitTo(input int t);
    while (cyc < t) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int e, d;
    rstN = 1'b0; busSel = 1'b0; busWrite = 1'b0; busAddr = '0; busWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;

    // R2 reset state
    rdChk("R2 reset ctrl", 5'h00, 32'h0);
    rdChk("R2 reset count", 5'h14, 32'h0);
    check("R2 reset irq", {30'd0, irq}, 32'h0);

    // R1 map and readback
    wr(5'h08, 32'hA5A5_0001); wr(5'h0C, 32'h1234_5678);
    wr(5'h18, 32'h0BAD_F00D); wr(5'h1C, 32'hCAFE_0002);
    wr(5'h09, 32'hFFFF_FFFF);
    rdChk("R1 ch0 reload1", 5'h08, 32'hA5A5_0001);
    rdChk("R1 ch0 reload2", 5'h0C, 32'h1234_5678);
    rdChk("R1 ch1 reload1", 5'h18, 32'h0BAD_F00D);
    rdChk("R1 ch1 reload2", 5'h1C, 32'hCAFE_0002);
    rdChk("R1 unaligned read", 5'h09, 32'h0);

    // R2 field readback, start without run; R3 no load
    wr(5'h00, (32'd3 << 10) | OUTLV | PER | IRQEN | UF | TRIG);
    rdChk("R2 ctrl readback", 5'h00, (32'd3 << 10) | OUTLV | PER | IRQEN);
    rdChk("R3 start without run", 5'h04, 32'h0);
    wr(5'h00, 32'h0);

    // R11 direct count write, run without start; R3 start-only no load
    wr(5'h04, 32'd5);
    wr(5'h00, TRIG);
    rdChk("R3 start-only keeps count", 5'h04, 32'd5);
    wr(5'h00, RUN);
    e = cyc;
    waitTo(e + 4);
    rdChk("R11 run from written count", 5'h04, 32'd3);
    wr(5'h00, 32'h0);
    rd(5'h04, v);
    repeat (10) @(posedge clk);
    #1;
    rdChk("R10 stopped count holds", 5'h04, v);

    // R4 R5 R7 R8 sweep over clock select and start value
    for (int sel = 0; sel < 5; sel++) begin
      for (int k = 0; k < 3; k++) begin
        int n;
        n = (k == 0) ? 0 : (k == 1) ? 1 : 3;
        d = (sel == 1) ? 8 : (sel == 2) ? 32 : (sel == 3) ? 64 : 2;
        wr(5'h00, 32'h0);
        wr(5'h08, n);
        wr(5'h00, (sel << 10) | IRQEN | RUN | TRIG);
        e = cyc;
        rdChk("R2 start reads zero", 5'h00, (sel << 10) | IRQEN | RUN);
        if (n > 0) begin
          waitTo(e + d - 1);
          rdChk("R4 before first decrement", 5'h04, n);
          waitTo(e + d);
          rdChk("R4 first decrement", 5'h04, n - 1);
        end
        waitTo(e + (n + 1) * d - 1);
        rdChk("R5 no underflow yet", 5'h00, (sel << 10) | IRQEN | RUN);
        rdChk("R5 count at zero", 5'h04, 32'h0);
        waitTo(e + (n + 1) * d);
        rdChk("R7 one-shot underflow ctrl", 5'h00, (sel << 10) | IRQEN | UF | OUTLV);
        check("R8 irq ch0 raised", {30'd0, irq}, 32'h1);
        waitTo(e + (n + 2) * d);
        rdChk("R7 count stays zero", 5'h04, 32'h0);
      end
    end

    // R8 disable interrupt, R9 write-1 keeps
    wr(5'h00, UF);
    check("R8 irq off without enable", {30'd0, irq}, 32'h0);
    rdChk("R9 write one keeps flag", 5'h00, UF);
    wr(5'h00, 32'h0);
    rdChk("R9 write zero clears", 5'h00, 32'h0);

    // R6 periodic on channel 1, R9 clear and collision
    wr(5'h18, 32'd2);
    wr(5'h10, PER | IRQEN | RUN | TRIG);
    e = cyc;
    waitTo(e + 5);
    rdChk("R6 before underflow", 5'h10, PER | IRQEN | RUN);
    waitTo(e + 6);
    rdChk("R6 underflow keeps running", 5'h10, PER | IRQEN | RUN | UF | OUTLV);
    rdChk("R6 reloaded", 5'h14, 32'd2);
    check("R8 irq ch1 raised", {30'd0, irq}, 32'h2);
    wr(5'h10, PER | IRQEN | RUN | OUTLV);
    rdChk("R9 flag cleared", 5'h10, PER | IRQEN | RUN | OUTLV);
    check("R8 irq ch1 dropped", {30'd0, irq}, 32'h0);
    waitTo(e + 11);
    rdChk("R6 second period count", 5'h14, 32'h0);
    waitTo(e + 12);
    rdChk("R6 second underflow", 5'h10, PER | IRQEN | RUN | UF);
    rdChk("R11 ch0 untouched", 5'h04, 32'h0);
    check("R11 ch0 irq untouched", {31'd0, irq[0]}, 32'h0);
    waitTo(e + 17);
    wr(5'h10, PER | IRQEN | RUN);
    rdChk("R9 set wins over clear", 5'h10, PER | IRQEN | RUN | UF);
    wr(5'h10, PER | IRQEN | RUN | UF);
    rdChk("R9 write one keeps", 5'h10, PER | IRQEN | RUN | UF);

    // R10 stop
    wr(5'h10, 32'h0);
    rdChk("R10 ctrl cleared", 5'h10, 32'h0);
    check("R10 irq dropped", {30'd0, irq}, 32'h0);
    rd(5'h14, v);
    repeat (20) @(posedge clk);
    #1;
    rdChk("R10 counter frozen", 5'h14, v);

    summary();
    $finish;
  end

endmodule